// File: doc/BRIEF.md
# Grouped Carry Increment Adder

This block adds two unsigned operands and a carry-in in purely combinational logic, giving a sum of the operand width and a carry-out. The operands are cut into 4-bit slices. Each slice has its own small adder. The lowest slice takes the external carry-in and its result goes straight to the output. Every slice above it adds its own operand bits with a carry-in of zero, which gives a single provisional result. A chain of half adders then bumps that provisional result by one when the slice below reports a carry. The block never computes a second candidate sum and never uses a selection multiplexer.

By default each slice adder is a 4-bit lookahead unit. It forms per-bit generate and propagate terms and computes all four internal carries in flat two-level logic. A parameter swaps in a 4-bit ripple slice instead, so that both builds of the same structure can be placed side by side and compared. The width must be a whole multiple of four. Any other value stops elaboration.

Because the block holds no state, there is no state machine, clock or reset. The house naming and layout are kept, and the behaviour is set only by the two parameters and the three inputs.

Top module: `cia_adder`

## Requirements
- R1: With the default lookahead slices and WIDTH=8, {cout, sum} equals a + b + cin for every combination of a, b and cin.
- R2: With USE_LOOKAHEAD=0 (ripple slices), {cout, sum} equals a + b + cin for every combination of a, b and cin at WIDTH=8.
- R3: At WIDTH=32 both slice variants give {cout, sum} = a + b + cin.
- R4: sum[3:0] equals the low four bits of a[3:0] + b[3:0] + cin and does not depend on any operand bit above bit 3.
- R5: A carry out of slice k-1 increments the provisional result of slice k. For example, 0x0F + 0x01 gives 0x10, and 0xFF + 0x00 + 1 gives sum 0x00 with cout 1.
- R6: Within a slice, the slice adder's own carry and the incrementer's final carry are never both 1. The carry that leaves the slice is their OR, so 0xFF + 0xFF + 1 gives sum 0xFF with cout 1.
- R7: For equal inputs, the lookahead and ripple builds give identical sum and cout.
- R8: All-zero inputs give sum 0 and cout 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | first operand |
| b | input | WIDTH | second operand |
| cin | input | 1 | carry into bit 0 |
| sum | output | WIDTH | low WIDTH bits of a + b + cin |
| cout | output | 1 | carry out of the top slice |

## Verification
The block has no state. A wrong internal carry therefore shows up in the same evaluation as the input change, but only in the upper slices' sum bits and in cout. It also only shows up for operand pairs whose lower slice actually overflows, or whose upper provisional result is all ones. The 8-bit builds are therefore swept over every input, so that each carry path is taken at least once. The 32-bit builds are driven with seeded random operands plus all-ones and carry-boundary patterns, which make a single carry ripple through every slice.

// File: rtl/cia_pkg.sv
package cia_pkg;

    // Width of one adder slice; the structure is built around this value.
    localparam int GRP_W = 4;

    typedef logic [GRP_W-1:0] nib_t;

    // Number of slices for a given operand width.
    function automatic int grp_count(input int width);
        return width / GRP_W;
    endfunction

endpackage

// File: rtl/cia_cla4.sv
// Four-bit lookahead slice: every carry is a flat sum of products.
module cia_cla4
    import cia_pkg::*;
(
    input  nib_t a,
    input  nib_t b,
    input  logic ci,
    output nib_t s,
    output logic co
);

    nib_t g;
    nib_t p;
    logic c1, c2, c3;

    always_comb begin
        g = a & b;
        p = a ^ b;
    end

    always_comb begin
        c1 = g[0] | (p[0] & ci);
        c2 = g[1] | (p[1] & g[0]) | (p[1] & p[0] & ci);
        c3 = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
           | (p[2] & p[1] & p[0] & ci);
        co = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
           | (p[3] & p[2] & p[1] & g[0])
           | (p[3] & p[2] & p[1] & p[0] & ci);
    end

    assign s = p ^ {c3, c2, c1, ci};

endmodule

// File: rtl/cia_rca4.sv
// Four-bit ripple slice: full adders chained bit by bit.
module cia_rca4
    import cia_pkg::*;
(
    input  nib_t a,
    input  nib_t b,
    input  logic ci,
    output nib_t s,
    output logic co
);

    logic [GRP_W:0] c;

    assign c[0] = ci;

    for (genvar i = 0; i < GRP_W; i++) begin : g_fa
        assign s[i]   = a[i] ^ b[i] ^ c[i];
        assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    assign co = c[GRP_W];

endmodule

// File: rtl/cia_grp4.sv
// One slice adder; the parameter picks lookahead or ripple carries.
module cia_grp4
    import cia_pkg::*;
#(
    parameter bit LOOKAHEAD = 1'b1
) (
    input  nib_t a,
    input  nib_t b,
    input  logic ci,
    output nib_t s,
    output logic co
);

    if (LOOKAHEAD) begin : g_la
        cia_cla4 u_cla (.a(a), .b(b), .ci(ci), .s(s), .co(co));
    end else begin : g_rc
        cia_rca4 u_rca (.a(a), .b(b), .ci(ci), .s(s), .co(co));
    end

endmodule

// File: rtl/cia_inc4.sv
// Conditional +1 on a slice result: half adders rippling upward from bit 0.
module cia_inc4
    import cia_pkg::*;
(
    input  nib_t x,
    input  logic ci,
    output nib_t y,
    output logic co
);

    logic [GRP_W:0] c;

    assign c[0] = ci;

    for (genvar i = 0; i < GRP_W; i++) begin : g_ha
        assign y[i]   = x[i] ^ c[i];
        assign c[i+1] = x[i] & c[i];
    end

    assign co = c[GRP_W];

endmodule

// File: rtl/cia_adder.sv
// Carry increment adder: slice 0 adds with cin, every upper slice adds
// with zero carry and is then incremented by the carry from below.
module cia_adder
    import cia_pkg::*;
#(
    parameter int WIDTH         = 8,
    parameter bit USE_LOOKAHEAD = 1'b1
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int NG = grp_count(WIDTH);

    if ((WIDTH % GRP_W) != 0 || WIDTH < GRP_W) begin : g_bad_width
        $error("cia_adder: WIDTH must be a positive multiple of 4");
    end

    // Carry entering each slice; index NG is the block's carry-out.
    logic [NG:0]   grp_carry;
    // Slice adder carry and incrementer carry per slice.
    logic [NG-1:0] gen_co;
    logic [NG-1:0] inc_co;

    assign grp_carry[0] = cin;

    for (genvar k = 0; k < NG; k++) begin : g_slice
        if (k == 0) begin : g_base
            cia_grp4 #(.LOOKAHEAD(USE_LOOKAHEAD)) u_add (
                .a  (a[GRP_W-1:0]),
                .b  (b[GRP_W-1:0]),
                .ci (grp_carry[0]),
                .s  (sum[GRP_W-1:0]),
                .co (gen_co[0])
            );
            assign inc_co[0]    = 1'b0;
            assign grp_carry[1] = gen_co[0];
        end else begin : g_upper
            nib_t psum;
            cia_grp4 #(.LOOKAHEAD(USE_LOOKAHEAD)) u_add (
                .a  (a[GRP_W*k +: GRP_W]),
                .b  (b[GRP_W*k +: GRP_W]),
                .ci (1'b0),
                .s  (psum),
                .co (gen_co[k])
            );
            cia_inc4 u_inc (
                .x  (psum),
                .ci (grp_carry[k]),
                .y  (sum[GRP_W*k +: GRP_W]),
                .co (inc_co[k])
            );
            assign grp_carry[k+1] = gen_co[k] | inc_co[k];
        end
    end

    assign cout = grp_carry[NG];

endmodule

// File: rtl/cia_adder_chk.sv
// Assertion checker bound into every cia_adder instance.
module cia_adder_chk
    import cia_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0]         a,
    input logic [WIDTH-1:0]         b,
    input logic                     cin,
    input logic [WIDTH-1:0]         sum,
    input logic                     cout,
    input logic [WIDTH/GRP_W:0]     grp_carry,
    input logic [WIDTH/GRP_W-1:0]   gen_co,
    input logic [WIDTH/GRP_W-1:0]   inc_co
);

    localparam int NG = WIDTH / GRP_W;
    localparam int EW = WIDTH + 1;

    logic [EW-1:0] total;
    logic [4:0]    low_total;

    always_comb begin
        total     = {1'b0, a} + {1'b0, b} + EW'(cin);
        low_total = {1'b0, a[3:0]} + {1'b0, b[3:0]} + 5'(cin);
    end

    always_comb begin
        if (!$isunknown({a, b, cin, sum, cout, grp_carry, gen_co, inc_co})) begin
            // R1 R2 R3
            sum_match_chk : assert ({cout, sum} == total)
                else $error("sum/cout differ from a+b+cin");
            // R4
            low_group_chk : assert (sum[3:0] == low_total[3:0])
                else $error("lowest slice sum wrong");
            for (int k = 1; k <= NG; k++) begin
                logic [EW-1:0] m;
                logic [EW-1:0] part;
                m    = (EW'(1) << (GRP_W * k)) - EW'(1);
                part = ({1'b0, a} & m) + ({1'b0, b} & m) + EW'(cin);
                // R5
                group_carry_chk : assert (grp_carry[k] == part[GRP_W * k])
                    else $error("carry into slice %0d wrong", k);
            end
            for (int k = 0; k < NG; k++) begin
                // R6
                carry_excl_chk : assert (!(gen_co[k] && inc_co[k]))
                    else $error("both carries set in slice %0d", k);
            end
        end
    end

endmodule

bind cia_adder cia_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a         (a),
    .b         (b),
    .cin       (cin),
    .sum       (sum),
    .cout      (cout),
    .grp_carry (grp_carry),
    .gen_co    (gen_co),
    .inc_co    (inc_co)
);

// File: tb/sim_cia_adder.sv
module sim_cia_adder;

    localparam int CLK_PERIOD = 10;
    localparam int WW         = 32;
    localparam int WDOG       = 190000;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [7:0]    a8, b8;
    logic          c8;
    logic [7:0]    s_la8, s_rc8;
    logic          co_la8, co_rc8;
    logic [WW-1:0] aw, bw;
    logic          cw;
    logic [WW-1:0] s_law, s_rcw;
    logic          co_law, co_rcw;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    cia_adder #(.WIDTH(8), .USE_LOOKAHEAD(1'b1)) u0 (
        .a(a8), .b(b8), .cin(c8), .sum(s_la8), .cout(co_la8));
    cia_adder #(.WIDTH(8), .USE_LOOKAHEAD(1'b0)) u1 (
        .a(a8), .b(b8), .cin(c8), .sum(s_rc8), .cout(co_rc8));
    cia_adder #(.WIDTH(WW), .USE_LOOKAHEAD(1'b1)) u2 (
        .a(aw), .b(bw), .cin(cw), .sum(s_law), .cout(co_law));
    cia_adder #(.WIDTH(WW), .USE_LOOKAHEAD(1'b0)) u3 (
        .a(aw), .b(bw), .cin(cw), .sum(s_rcw), .cout(co_rcw));

    function automatic logic [8:0] ref8(input logic [7:0] x, input logic [7:0] y,
                                        input logic c);
        int t;
        t = int'(x) + int'(y) + int'(c);
        return t[8:0];
    endfunction

    function automatic logic [WW:0] refw(input logic [WW-1:0] x,
                                         input logic [WW-1:0] y, input logic c);
        longint t;
        t = longint'(x) + longint'(y) + longint'(c);
        return t[WW:0];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h (a8=%0h b8=%0h c8=%0b aw=%0h bw=%0h cw=%0b)",
                     req, act, exp, a8, b8, c8, aw, bw, cw);
        end
    endtask

    task automatic check_all();
        logic [8:0]  e8;
        logic [WW:0] ew;
        logic [4:0]  lo;
        e8 = ref8(a8, b8, c8);
        ew = refw(aw, bw, cw);
        lo = 5'(a8[3:0]) + 5'(b8[3:0]) + 5'(c8);
        chk("R1", 64'({co_la8, s_la8}), 64'(e8));
        chk("R2", 64'({co_rc8, s_rc8}), 64'(e8));
        chk("R7", 64'({co_la8, s_la8}), 64'({co_rc8, s_rc8}));
        chk("R4", 64'(s_la8[3:0]), 64'(lo[3:0]));
        chk("R3", 64'({co_law, s_law}), 64'(ew));
        chk("R3", 64'({co_rcw, s_rcw}), 64'(ew));
    endtask

    task automatic apply(input logic [7:0] x, input logic [7:0] y, input logic c,
                         input logic [WW-1:0] xw, input logic [WW-1:0] yw, input logic cc);
        @(posedge clk);
        a8 = x; b8 = y; c8 = c;
        aw = xw; bw = yw; cw = cc;
        @(negedge clk);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1C0DE));
        a8 = '0; b8 = '0; c8 = 1'b0;
        aw = '0; bw = '0; cw = 1'b0;

        // R8: all-zero inputs
        apply(8'h00, 8'h00, 1'b0, '0, '0, 1'b0);
        chk("R8", 64'({co_la8, s_la8}), 64'h0);
        chk("R8", 64'({co_law, s_law}), 64'h0);

        // R5: carry from slice 0 increments slice 1
        apply(8'h0F, 8'h01, 1'b0, 32'h0000_FFFF, 32'h1, 1'b0);
        chk("R5", 64'({co_la8, s_la8}), 64'h010);
        chk("R5", 64'({co_law, s_law}), 64'h0_0001_0000);

        // R5: carry-in runs the full length
        apply(8'hFF, 8'h00, 1'b1, '1, '0, 1'b1);
        chk("R5", 64'({co_la8, s_la8}), 64'h100);
        chk("R5", 64'({co_rcw, s_rcw}), 64'h1_0000_0000);

        // R6: maximum operands
        apply(8'hFF, 8'hFF, 1'b1, '1, '1, 1'b1);
        chk("R6", 64'({co_la8, s_la8}), 64'h1FF);
        chk("R6", 64'({co_rc8, s_rc8}), 64'h1FF);
        chk("R6", 64'({co_law, s_law}), 64'h1_FFFF_FFFF);

        // R4: upper operand bits do not change the lowest slice
        apply(8'h07, 8'h08, 1'b1, '0, '0, 1'b0);
        chk("R4", 64'(s_la8[3:0]), 64'h0);
        apply(8'hA7, 8'h58, 1'b1, '0, '0, 1'b0);
        chk("R4", 64'(s_la8[3:0]), 64'h0);

        // R1 R2 R7 R4 R3: exhaustive 8-bit sweep with random wide vectors
        for (int i = 0; i < 512; i++) begin
            for (int j = 0; j < 256; j++) begin
                logic [WW-1:0] rx, ry;
                rx = $urandom;
                ry = $urandom;
                if (j[3:0] == 4'd0) ry = ~rx;
                apply(i[7:0], j[7:0], i[8], rx, ry, j[4]);
                check_all();
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule